// File: doc/BRIEF.md
# Narrow Feistel Line-Address Scrambler

This block applies a keyed, reversible permutation to a 40-bit physical cache-line address. The last-level cache uses the scrambled value as its set index and tag. Lines that would otherwise share a set are therefore spread across the cache in a way that depends on the key. When a dirty line is evicted, the same block runs in the opposite direction with the same key. This recovers the exact physical line address, and the line is written back there.

The cipher is a four-round balanced Feistel network over two 20-bit halves. Each round uses a small substitution-permutation function, so its logic stays shallow. The pipeline has two register stages, each evaluating two rounds. A new address can be accepted on every clock cycle, and its result appears two cycles later with a valid flag. A mode bit on each request selects the forward or inverse direction. The key is supplied with every request, so requests that follow one another back-to-back may use different keys and directions.

Top module: `addr_cipher`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after the second rising edge that follows, and `out_valid` is never high unless `in_valid` was high two edges before.
- R2: Requests on consecutive cycles are all accepted, with no gap between them. Their results come out on consecutive cycles in the same order.
- R3: Scrambling an address with `in_decrypt`=0 and then feeding the result back with `in_decrypt`=1 and the same key returns the original address bit for bit.
- R4: Applying the inverse direction first and then the forward direction with the same key also returns the original address.
- R5: While `out_valid` is low, `out_addr` keeps the last value it presented, whatever the inputs do.
- R6: A fixed address scrambled under different keys gives a different result for each key.
- R7: While `rst_n` is low, `out_valid` is 0 and `out_addr` is 0.
- R8: Identical requests on consecutive cycles give identical results on consecutive cycles.
- R9: The block has a left half L=`in_addr[39:20]` and a right half R=`in_addr[19:0]`. Round key i (i=0..3) is bits [19:0] of the key rotated left by 10*i bits. The forward direction uses the keys in the order 0,1,2,3 and the inverse direction uses them in the order 3,2,1,0. The round function XORs R with the round key. It then maps each nibble through the 16-entry table 6,B,0,D,3,E,9,4,F,1,C,7,A,2,8,5 (input 0 first). Finally it moves bit b to bit (7*b mod 20). Rounds 0 to 2 set (L,R) to (R, L^f). Round 3 sets L to L^f and leaves R unchanged. The output is {L,R}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one address per cycle |
| in_addr | input | 40 | Line address to transform |
| in_key | input | 40 | Key for this request |
| in_decrypt | input | 1 | 0 selects the forward direction, 1 the inverse |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_addr | output | 40 | Transformed line address |

## Verification
The bench sends requests back-to-back and alternates keys and directions from one cycle to the next. A design that registered the stage-two round keys out of step with the data would mix two requests' keys, and those results would not match. The round trip is checked in both directions on random keys. That check fails if the inverse key order is wrong, or if the final round swaps its halves, because the address would then come back permuted instead of exact. Further checks cover the exact two-cycle valid timing and the output holding its value in idle cycles. The key rotation must reach bits above 19, so keys that differ only in those bits must give different results.

// File: rtl/addr_cipher_pkg.sv
package addr_cipher_pkg;

    localparam int NIB_W    = 4;
    localparam int PERM_MUL = 7;

    // Fixed 4-bit substitution used by every nibble of the round function.
    function automatic logic [NIB_W-1:0] sbox4(input logic [NIB_W-1:0] x);
        logic [NIB_W-1:0] y;
        case (x)
            4'h0: y = 4'h6;
            4'h1: y = 4'hB;
            4'h2: y = 4'h0;
            4'h3: y = 4'hD;
            4'h4: y = 4'h3;
            4'h5: y = 4'hE;
            4'h6: y = 4'h9;
            4'h7: y = 4'h4;
            4'h8: y = 4'hF;
            4'h9: y = 4'h1;
            4'hA: y = 4'hC;
            4'hB: y = 4'h7;
            4'hC: y = 4'hA;
            4'hD: y = 4'h2;
            4'hE: y = 4'h8;
            default: y = 4'h5;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/cipher_round_fn.sv
module cipher_round_fn
    import addr_cipher_pkg::*;
#(
    parameter int HALF_W = 20
) (
    input  logic [HALF_W-1:0] half_in,
    input  logic [HALF_W-1:0] round_key,
    output logic [HALF_W-1:0] mix_out
);
    localparam int NUM_NIB = HALF_W / NIB_W;

    logic [HALF_W-1:0] keyed;
    logic [HALF_W-1:0] subst;

    assign keyed = half_in ^ round_key;

    // Substitution layer: one table per nibble.
    for (genvar n = 0; n < NUM_NIB; n++) begin : g_sbox
        assign subst[n*NIB_W +: NIB_W] = sbox4(keyed[n*NIB_W +: NIB_W]);
    end

    // Permutation layer: bit b moves to (PERM_MUL*b) mod HALF_W.
    for (genvar b = 0; b < HALF_W; b++) begin : g_perm
        localparam int DST = (b * PERM_MUL) % HALF_W;
        assign mix_out[DST] = subst[b];
    end
endmodule

// File: rtl/cipher_round.sv
module cipher_round #(
    parameter int HALF_W = 20,
    parameter bit FINAL  = 1'b0
) (
    input  logic [HALF_W-1:0] l_in,
    input  logic [HALF_W-1:0] r_in,
    input  logic [HALF_W-1:0] round_key,
    output logic [HALF_W-1:0] l_out,
    output logic [HALF_W-1:0] r_out
);
    logic [HALF_W-1:0] f_val;

    cipher_round_fn #(.HALF_W(HALF_W)) u_fn (
        .half_in   (r_in),
        .round_key (round_key),
        .mix_out   (f_val)
    );

    if (FINAL) begin : g_noswap
        assign l_out = l_in ^ f_val;
        assign r_out = r_in;
    end else begin : g_swap
        assign l_out = r_in;
        assign r_out = l_in ^ f_val;
    end
endmodule

// File: rtl/cipher_keysched.sv
module cipher_keysched #(
    parameter int BLK_W   = 40,
    parameter int ROUNDS  = 4,
    parameter int KEY_ROT = 10
) (
    input  logic [BLK_W-1:0]              key,
    input  logic                          inverse,
    output logic [ROUNDS*(BLK_W/2)-1:0]   rk_flat
);
    localparam int HALF_W = BLK_W / 2;

    logic [2*BLK_W-1:0]  key_dbl;
    logic [HALF_W-1:0]   fwd_rk [ROUNDS];

    assign key_dbl = {key, key};

    // Forward round key i: low half of key rotated left by KEY_ROT*i.
    for (genvar i = 0; i < ROUNDS; i++) begin : g_rot
        localparam int SH = (KEY_ROT * i) % BLK_W;
        logic [BLK_W-1:0] rotated;
        assign rotated   = key_dbl[2*BLK_W-1-SH -: BLK_W];
        assign fwd_rk[i] = rotated[HALF_W-1:0];
    end

    // Inverse direction walks the same keys in reverse order.
    for (genvar i = 0; i < ROUNDS; i++) begin : g_order
        assign rk_flat[i*HALF_W +: HALF_W] = inverse ? fwd_rk[ROUNDS-1-i] : fwd_rk[i];
    end
endmodule

// File: rtl/cipher_stage.sv
module cipher_stage #(
    parameter int HALF_W     = 20,
    parameter int NR         = 2,
    parameter bit LAST_STAGE = 1'b0
) (
    input  logic [HALF_W-1:0]    l_in,
    input  logic [HALF_W-1:0]    r_in,
    input  logic [NR*HALF_W-1:0] rk,
    output logic [HALF_W-1:0]    l_out,
    output logic [HALF_W-1:0]    r_out
);
    logic [HALF_W-1:0] l_c [NR+1];
    logic [HALF_W-1:0] r_c [NR+1];

    assign l_c[0] = l_in;
    assign r_c[0] = r_in;

    for (genvar j = 0; j < NR; j++) begin : g_rnd
        localparam bit IS_FINAL = LAST_STAGE && (j == NR - 1);
        cipher_round #(.HALF_W(HALF_W), .FINAL(IS_FINAL)) u_rnd (
            .l_in      (l_c[j]),
            .r_in      (r_c[j]),
            .round_key (rk[j*HALF_W +: HALF_W]),
            .l_out     (l_c[j+1]),
            .r_out     (r_c[j+1])
        );
    end

    assign l_out = l_c[NR];
    assign r_out = r_c[NR];
endmodule

// File: rtl/addr_cipher.sv
module addr_cipher #(
    parameter int BLK_W     = 40,
    parameter int PER_STAGE = 2,
    parameter int KEY_ROT   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BLK_W-1:0] in_addr,
    input  logic [BLK_W-1:0] in_key,
    input  logic             in_decrypt,
    output logic             out_valid,
    output logic [BLK_W-1:0] out_addr
);
    localparam int HALF_W = BLK_W / 2;
    localparam int ROUNDS = 2 * PER_STAGE;
    localparam int RKS_W  = PER_STAGE * HALF_W;

    typedef struct packed {
        logic             v1;
        logic [HALF_W-1:0] l1;
        logic [HALF_W-1:0] r1;
        logic [RKS_W-1:0]  rk1;
        logic              v2;
        logic [BLK_W-1:0]  res;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [ROUNDS*HALF_W-1:0] rk_all;
    logic [HALF_W-1:0]        s1_l, s1_r, s2_l, s2_r;

    cipher_keysched #(.BLK_W(BLK_W), .ROUNDS(ROUNDS), .KEY_ROT(KEY_ROT)) u_ks (
        .key     (in_key),
        .inverse (in_decrypt),
        .rk_flat (rk_all)
    );

    cipher_stage #(.HALF_W(HALF_W), .NR(PER_STAGE), .LAST_STAGE(1'b0)) u_st1 (
        .l_in  (in_addr[BLK_W-1:HALF_W]),
        .r_in  (in_addr[HALF_W-1:0]),
        .rk    (rk_all[RKS_W-1:0]),
        .l_out (s1_l),
        .r_out (s1_r)
    );

    cipher_stage #(.HALF_W(HALF_W), .NR(PER_STAGE), .LAST_STAGE(1'b1)) u_st2 (
        .l_in  (st_q.l1),
        .r_in  (st_q.r1),
        .rk    (st_q.rk1),
        .l_out (s2_l),
        .r_out (s2_r)
    );

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        if (in_valid) begin
            st_d.l1  = s1_l;
            st_d.r1  = s1_r;
            st_d.rk1 = rk_all[ROUNDS*HALF_W-1:RKS_W];
        end
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.res = {s2_l, s2_r};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v2;
    assign out_addr  = st_q.res;
endmodule

// File: rtl/addr_cipher_chk.sv
module addr_cipher_chk #(
    parameter int BLK_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [BLK_W-1:0] in_addr,
    input logic [BLK_W-1:0] in_key,
    input logic             in_decrypt,
    input logic             out_valid,
    input logic [BLK_W-1:0] out_addr
);
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_addr));

    a_r8_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)
         && $past(in_addr, 2) == $past(in_addr, 3)
         && $past(in_key, 2) == $past(in_key, 3)
         && $past(in_decrypt, 2) == $past(in_decrypt, 3))
        |-> out_addr == $past(out_addr));
endmodule

bind addr_cipher addr_cipher_chk #(.BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .in_key     (in_key),
    .in_decrypt (in_decrypt),
    .out_valid  (out_valid),
    .out_addr   (out_addr)
);

// File: tb/sim_addr_cipher.sv
`timescale 1ns/1ps
module sim_addr_cipher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [39:0] in_addr = '0;
    logic [39:0] in_key = '0;
    logic        in_decrypt = 1'b0;
    logic        out_valid;
    logic [39:0] out_addr;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    addr_cipher u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_key(in_key), .in_decrypt(in_decrypt),
        .out_valid(out_valid), .out_addr(out_addr)
    );

    // Stimulus table: {decrypt, key, addr}
    localparam int NV = 10;
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 40'h00_0000_0000, 40'h00_0000_0000},
        {1'b0, 40'h00_0000_0000, 40'hFF_FFFF_FFFF},
        {1'b0, 40'h12_3456_789A, 40'h00_0000_0001},
        {1'b1, 40'h12_3456_789A, 40'h00_0000_0001},
        {1'b0, 40'hFF_FFFF_FFFF, 40'h80_0000_0000},
        {1'b1, 40'hA5_5A_A55A5, 40'h0F_0F0F_0F0F},
        {1'b0, 40'hDE_ADBE_EF01, 40'hCA_FE00_0000},
        {1'b0, 40'h01_0000_0000, 40'hCA_FE00_0000},
        {1'b1, 40'h00_0001_0000, 40'h13_5792_4680},
        {1'b0, 40'h7E_57C0_FFEE, 40'h3C_3C3C_3C3C}
    };

    function automatic logic [3:0] tb_sb(input logic [3:0] x);
        logic [3:0] t [16] = '{4'h6, 4'hB, 4'h0, 4'hD, 4'h3, 4'hE, 4'h9, 4'h4,
                               4'hF, 4'h1, 4'hC, 4'h7, 4'hA, 4'h2, 4'h8, 4'h5};
        return t[x];
    endfunction

    // Reference model written from R9.
    function automatic logic [39:0] ref_cipher(input logic [39:0] a, input logic [39:0] k,
                                               input logic dec);
        logic [19:0] l, r, x, s, p, rk;
        logic [79:0] d;
        logic [39:0] rot;
        int idx;
        l = a[39:20];
        r = a[19:0];
        d = {k, k};
        for (int rnd = 0; rnd < 4; rnd++) begin
            idx = dec ? 3 - rnd : rnd;
            rot = 40'(d >> (40 - 10 * idx));
            rk  = rot[19:0];
            x   = r ^ rk;
            for (int n = 0; n < 5; n++) s[n*4 +: 4] = tb_sb(x[n*4 +: 4]);
            for (int b = 0; b < 20; b++) p[(b * 7) % 20] = s[b];
            if (rnd == 3) l = l ^ p;
            else begin
                x = l ^ p;
                l = r;
                r = x;
            end
        end
        return {l, r};
    endfunction

    task automatic check(input bit ok, input string req, input logic [39:0] act,
                         input logic [39:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Single request; returns the result sampled two edges later.
    task automatic run_one(input logic [39:0] a, input logic [39:0] k, input logic dec,
                           output logic [39:0] res);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_key = k; in_decrypt = dec;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R1", 40'(out_valid), 40'd1);
        res = out_addr;
    endtask

    logic [39:0] got, back, last, fixed_res [4];
    logic [39:0] ra, rk;

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", 40'(out_valid), 40'd0);
        check(out_addr == '0, "R7", out_addr, 40'd0);
        rst_n = 1'b1;

        // R2 and R9: table streamed back-to-back
        for (int k = 0; k < NV + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                got = ref_cipher(VEC[k-2][39:0], VEC[k-2][79:40], VEC[k-2][80]);
                check(out_valid == 1'b1, "R2", 40'(out_valid), 40'd1);
                check(out_addr == got, "R9", out_addr, got);
                last = got;
            end
            if (k < NV) begin
                in_valid = 1'b1;
                in_addr = VEC[k][39:0]; in_key = VEC[k][79:40]; in_decrypt = VEC[k][80];
            end else begin
                in_valid = 1'b0;
            end
        end

        // R5: output held while idle, inputs changing
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R5", 40'(out_valid), 40'd0);
            check(out_addr == last, "R5", out_addr, last);
            in_addr = {$urandom, $urandom};
            in_key  = {$urandom, $urandom};
        end

        // R1: single pulse timing
        @(negedge clk);
        in_valid = 1'b1; in_addr = 40'h55_AA55_AA55; in_key = 40'h01_2345_6789; in_decrypt = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R1", 40'(out_valid), 40'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R1", 40'(out_valid), 40'd1);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", 40'(out_valid), 40'd0);

        // R3 / R4: round trips on random keys and addresses
        for (int t = 0; t < 24; t++) begin
            ra = {$urandom, $urandom};
            rk = {$urandom, $urandom};
            run_one(ra, rk, 1'b0, got);
            run_one(got, rk, 1'b1, back);
            check(back == ra, "R3", back, ra);
            run_one(ra, rk, 1'b1, got);
            run_one(got, rk, 1'b0, back);
            check(back == ra, "R4", back, ra);
        end

        // R6: fixed address, keys differing in high and low bits
        run_one(40'h00_1234_5678, 40'h00_0000_0000, 1'b0, fixed_res[0]);
        run_one(40'h00_1234_5678, 40'h80_0000_0000, 1'b0, fixed_res[1]);
        run_one(40'h00_1234_5678, 40'h00_0000_0001, 1'b0, fixed_res[2]);
        run_one(40'h00_1234_5678, 40'h00_4000_0000, 1'b0, fixed_res[3]);
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++)
                check(fixed_res[i] != fixed_res[j], "R6", fixed_res[i], fixed_res[j]);

        // R8: identical requests on consecutive cycles
        @(negedge clk);
        in_valid = 1'b1; in_addr = 40'h9A_BCDE_F012; in_key = 40'h33_4455_6677; in_decrypt = 1'b1;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        got = out_addr;
        check(out_valid == 1'b1, "R8", 40'(out_valid), 40'd1);
        @(negedge clk);
        check(out_valid == 1'b1 && out_addr == got, "R8", out_addr, got);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule